// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every bus access, whether the access may proceed or must raise a fault. It holds eight programmable protection regions. Each region has a base address, a power-of-two size, eight equally sized subregions that can be switched off one by one, an access-permission code and an execute-never flag. An access carries an address, a privileged flag, a write flag and an instruction-fetch flag. The checker returns an allow/fault verdict and the index of the region that decided it. The verdict is purely combinational.

Privileged software programs the table through a small write port. It offers four registers: a region select, a base-address register, an attribute/size register and a control register. The base-address register can also select the region it writes. The control register turns the checker on and can enable a privileged-only background map. That map applies when no region matches. Unprivileged configuration writes are refused and flagged. Cache, buffer, share and type bits are stored but do not affect the verdict.

Top module: `mem_prot_chk`

## Requirements
- R1: Eight regions, numbered 0 to 7. The cfg_sel_i codes are 0 = select, 1 = base, 2 = attribute, 3 = control. A select write takes region index wdata[2:0]. A base write stores wdata[31:5] as base bits 31:5 with the low bits zero. If wdata[4] is set and wdata[3:0] is below 8, the base write goes to region wdata[3:0] and also makes that region the selected one. Otherwise it goes to the selected region. An attribute write goes to the selected region with this layout: execute-never bit 28, permission 26:24, type/cache/buffer/share 21:16, subregion disables 15:8, size code 5:1, enable bit 0.
- R2: An enabled region with size code S covers 2^(S+1) bytes from its base. Address bits below S+1 are ignored in the match.
- R3: When several matching regions overlap, the highest-numbered one decides. acc_region_o reports it and acc_hit_o is 1.
- R4: For S >= 7, a region is split into eight subregions numbered from its bottom. Subregion k covers offsets k*2^(S-2) up to (k+1)*2^(S-2)-1. When disable bit 8+k is set, that subregion does not match, and the access falls through to lower regions or to the background.
- R5: Permission codes behave as follows. 000 and 100: no access. 001: privileged read/write only. 010: privileged read/write, unprivileged read. 011: full access. 101: privileged read only. 110 and 111: read only for both.
- R6: An instruction fetch is checked as a read. It faults in a matching region whose execute-never bit is set, whatever the permission code.
- R7: An access that matches no region is allowed only if it is privileged and background-enable (control bit 2) is set. Otherwise it faults, with acc_hit_o = 0 and acc_region_o = 0.
- R8: While enable (control bit 0) is clear, which is the state after reset, every access is allowed with acc_hit_o = 0 and acc_region_o = 0.
- R9: A configuration write with cfg_priv_i = 0 raises cfg_err_o in the same cycle and changes no register.
- R10: A privileged configuration write takes effect at the next rising clock edge. The verdict for later accesses follows the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 1 | Configuration write is privileged |
| cfg_sel_i | input | 2 | Register select (0 select, 1 base, 2 attribute, 3 control) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_err_o | output | 1 | Refused unprivileged configuration write |
| acc_addr_i | input | 32 | Access address |
| acc_priv_i | input | 1 | Access is privileged |
| acc_write_i | input | 1 | Access is a write |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_allow_o | output | 1 | Access allowed (0 = fault) |
| acc_hit_o | output | 1 | A region decided the access |
| acc_region_o | output | 3 | Index of the deciding region |

## Verification
A wrong stored base, size or subregion mask shows up on the first access near a region edge. acc_hit_o or acc_region_o points at a lower region, or acc_allow_o flips, in the same cycle as the access. A corrupted priority or permission decode shows up as the wrong region index or verdict on overlapping addresses. A leaked unprivileged write shows only on a later access whose verdict depends on the register it touched. The bench therefore probes addresses just inside and just outside each region and subregion edge, after each reconfiguration.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    SEL_RNR  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_CTRL = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              xn;
    logic [2:0]        ap;
    logic [5:0]        mem_attr;  // stored only
    logic [7:0]        srd;
    logic [4:0]        size;
    logic              en;
    logic [ADDR_W-1:0] base;
  } region_t;

  function automatic logic ap_permits(input logic [2:0] ap, input logic priv,
                                      input logic wr);
    logic ok;
    case (ap)
      3'b001:        ok = priv;
      3'b010:        ok = priv | ~wr;
      3'b011:        ok = 1'b1;
      3'b101:        ok = priv & ~wr;
      3'b110, 3'b111: ok = ~wr;
      default:       ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/mp_cfg_regs.sv
module mp_cfg_regs
  import mp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic              err_o,
  output region_t           rg_o [NUM_REGIONS],
  output logic              en_o,
  output logic              bg_o
);
  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] tgt_idx;
  logic             wr_ok;
  logic             direct;

  assign wr_ok  = we_i & priv_i;
  assign err_o  = we_i & ~priv_i;
  assign direct = (cfg_sel_e'(sel_i) == SEL_BASE) && wdata_i[4] &&
                  (32'(wdata_i[3:0]) < NUM_REGIONS);
  assign tgt_idx = direct ? IDX_W'(wdata_i[3:0]) : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_o  <= 1'b0;
      bg_o  <= 1'b0;
    end else if (wr_ok) begin
      case (cfg_sel_e'(sel_i))
        SEL_RNR:  sel_q <= IDX_W'(wdata_i);
        SEL_BASE: if (direct) sel_q <= tgt_idx;
        SEL_CTRL: begin
          en_o <= wdata_i[0];
          bg_o <= wdata_i[2];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rg_o[g] <= '0;
      end else if (wr_ok && tgt_idx == IDX_W'(g)) begin
        if (cfg_sel_e'(sel_i) == SEL_BASE) begin
          rg_o[g].base <= {wdata_i[ADDR_W-1:5], 5'b0};
        end else if (cfg_sel_e'(sel_i) == SEL_ATTR) begin
          rg_o[g].xn       <= wdata_i[28];
          rg_o[g].ap       <= wdata_i[26:24];
          rg_o[g].mem_attr <= wdata_i[21:16];
          rg_o[g].srd      <= wdata_i[15:8];
          rg_o[g].size     <= wdata_i[5:1];
          rg_o[g].en       <= wdata_i[0];
        end
      end
    end
  end
endmodule

// File: rtl/mp_region_match.sv
module mp_region_match
  import mp_pkg::*;
(
  input  region_t           rg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned MIN_SUB_SIZE = 7;  // 256 bytes

  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] low_mask;
  logic              in_range;
  logic [2:0]        sub_idx;
  logic              sub_off;

  always_comb begin
    span     = (ADDR_W+1)'(1) << (6'(rg_i.size) + 6'd1);
    low_mask = ADDR_W'(span - (ADDR_W+1)'(1));
    in_range = ((addr_i ^ rg_i.base) & ~low_mask) == '0;
    sub_idx  = '0;
    sub_off  = 1'b0;
    if (32'(rg_i.size) >= MIN_SUB_SIZE) begin
      sub_idx = 3'(addr_i >> (rg_i.size - 5'd2));
      sub_off = rg_i.srd[sub_idx];
    end
    hit_o = rg_i.en & in_range & ~sub_off;
  end
endmodule

// File: rtl/mp_prio_sel.sv
module mp_prio_sel #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  // later (higher) index overrides earlier
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mem_prot_chk.sv
module mem_prot_chk
  import mp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              cfg_err_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_priv_i,
  input  logic              acc_write_i,
  input  logic              acc_fetch_i,
  output logic              acc_allow_o,
  output logic              acc_hit_o,
  output logic [IDX_W-1:0]  acc_region_o
);
  region_t                rg [NUM_REGIONS];
  logic                   en_q, bg_q;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] xn_vec;
  logic [NUM_REGIONS-1:0] en_vec;
  logic                   found;
  logic [IDX_W-1:0]       win_idx;
  region_t                win;
  logic                   perm_ok;

  mp_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .priv_i  (cfg_priv_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .err_o   (cfg_err_o),
    .rg_o    (rg),
    .en_o    (en_q),
    .bg_o    (bg_q)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mp_region_match u_match (
      .rg_i   (rg[g]),
      .addr_i (acc_addr_i),
      .hit_o  (hit_vec[g])
    );
    assign xn_vec[g] = rg[g].xn;
    assign en_vec[g] = rg[g].en;
  end

  mp_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hit_i   (hit_vec),
    .found_o (found),
    .idx_o   (win_idx)
  );

  assign win     = rg[win_idx];
  assign perm_ok = ap_permits(win.ap, acc_priv_i, acc_write_i & ~acc_fetch_i);

  always_comb begin
    acc_allow_o  = 1'b1;
    acc_hit_o    = 1'b0;
    acc_region_o = '0;
    if (en_q) begin
      if (found) begin
        acc_hit_o    = 1'b1;
        acc_region_o = win_idx;
        acc_allow_o  = perm_ok & ~(acc_fetch_i & win.xn);
      end else begin
        acc_allow_o = acc_priv_i & bg_q;
      end
    end
  end
endmodule

// File: rtl/mp_chk.sv
module mp_chk #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_we_i,
  input logic                   cfg_priv_i,
  input logic [1:0]             cfg_sel_i,
  input logic [31:0]            cfg_wdata_i,
  input logic                   acc_priv_i,
  input logic                   acc_fetch_i,
  input logic                   acc_allow_o,
  input logic                   acc_hit_o,
  input logic [IDX_W-1:0]       acc_region_o,
  input logic                   en_q,
  input logic                   bg_q,
  input logic [NUM_REGIONS-1:0] xn_vec,
  input logic [NUM_REGIONS-1:0] en_vec
);
  // R8
  off_allows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> acc_allow_o && !acc_hit_o);

  // R7
  unpriv_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !acc_hit_o && !acc_priv_i |-> !acc_allow_o);

  // R6
  xn_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit_o && acc_fetch_i && xn_vec[acc_region_o] |-> !acc_allow_o);

  // R3
  hit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit_o |-> en_vec[acc_region_o]);

  // R9
  unpriv_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_priv_i |=> $stable(en_q) && $stable(bg_q) && $stable(en_vec));

  // R10
  ctrl_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_priv_i && cfg_sel_i == 2'd3 |=>
      en_q == $past(cfg_wdata_i[0]) && bg_q == $past(cfg_wdata_i[2]));
endmodule

bind mem_prot_chk mp_chk #(.NUM_REGIONS(NUM_REGIONS)) u_mp_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_priv_i   (cfg_priv_i),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .acc_priv_i   (acc_priv_i),
  .acc_fetch_i  (acc_fetch_i),
  .acc_allow_o  (acc_allow_o),
  .acc_hit_o    (acc_hit_o),
  .acc_region_o (acc_region_o),
  .en_q         (en_q),
  .bg_q         (bg_q),
  .xn_vec       (xn_vec),
  .en_vec       (en_vec)
);

// File: tb/sim_mem_prot_chk.sv
module sim_mem_prot_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_err;
  logic [31:0] addr = '0;
  logic        priv = 1'b0, wr = 1'b0, fetch = 1'b0;
  logic        allow, hit;
  logic [2:0]  region;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    is_cfg;
    bit    err;
    bit    allow;
    bit    hit;
    int    region;
    string tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  mem_prot_chk u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_err_o(cfg_err),
    .acc_addr_i(addr), .acc_priv_i(priv), .acc_write_i(wr), .acc_fetch_i(fetch),
    .acc_allow_o(allow), .acc_hit_o(hit), .acc_region_o(region)
  );

  task automatic cfg(input logic [1:0] s, input logic [31:0] d, input bit p,
                     input bit exp_err, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = p; cfg_sel = s; cfg_wdata = d;
    addr = '0; priv = 1'b0; wr = 1'b0; fetch = 1'b0;
    it.is_cfg = 1'b1; it.err = exp_err; it.allow = 1'b0; it.hit = 1'b0;
    it.region = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic acc(input logic [31:0] a, input bit p, input bit w, input bit f,
                     input bit e_allow, input bit e_hit, input int e_reg,
                     input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    addr = a; priv = p; wr = w; fetch = f;
    it.is_cfg = 1'b0; it.err = 1'b0; it.allow = e_allow; it.hit = e_hit;
    it.region = e_reg; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.is_cfg) begin
          if (cfg_err !== it.err) begin
            errors++;
            $display("FAIL %s: cfg_err=%0b expected %0b", it.tag, cfg_err, it.err);
          end
        end else if (allow !== it.allow || hit !== it.hit ||
                     int'(region) != it.region || cfg_err !== 1'b0) begin
          errors++;
          $display("FAIL %s: allow/hit/region=%0b/%0b/%0d expected %0b/%0b/%0d",
                   it.tag, allow, hit, region, it.allow, it.hit, it.region);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state: checker off
    acc(32'h2020_6800, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 reset allow");
    @(negedge clk); rst_n = 1'b1;
    acc(32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R8 after reset allow");

    // R1 direct base writes with valid bit, then attribute
    cfg(2'd1, 32'h2020_0010, 1'b1, 1'b0, "R1 base r0");
    cfg(2'd2, 32'h0300_C01D, 1'b1, 1'b0, "R1 attr r0");  // 32KB full, top 8KB off
    cfg(2'd1, 32'h2020_7814, 1'b1, 1'b0, "R1 base r4");
    cfg(2'd2, 32'h0300_0015, 1'b1, 1'b0, "R1 attr r4");  // 2KB full
    cfg(2'd1, 32'h0000_0012, 1'b1, 1'b0, "R1 base r2");
    cfg(2'd2, 32'h0600_001F, 1'b1, 1'b0, "R1 attr r2");  // 64KB read only
    cfg(2'd1, 32'h0000_8013, 1'b1, 1'b0, "R1 base r3");
    cfg(2'd2, 32'h1300_001D, 1'b1, 1'b0, "R1 attr r3");  // 32KB full, xn
    cfg(2'd1, 32'h4000_0011, 1'b1, 1'b0, "R1 base r1");
    cfg(2'd2, 32'h0100_0017, 1'b1, 1'b0, "R1 attr r1");  // 4KB priv only
    // R1 select register path, base with valid clear
    cfg(2'd0, 32'h0000_0005, 1'b1, 1'b0, "R1 sel r5");
    cfg(2'd1, 32'h2020_1000, 1'b1, 1'b0, "R1 base r5");
    cfg(2'd2, 32'h0500_000F, 1'b1, 1'b0, "R1 attr r5");  // 256B priv ro
    cfg(2'd3, 32'h0000_0005, 1'b1, 1'b0, "R10 ctrl en+bg");

    acc(32'h2020_0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 0, "R5 full access r0");
    acc(32'h2020_7C00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4, "R3 r4 over r0");
    acc(32'h2020_6800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R4 disabled subregion unpriv");
    acc(32'h2020_5FFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, "R4 last enabled subregion");
    acc(32'h2020_6800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R7 privileged background");
    acc(32'h2020_1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5, "R5 priv ro unpriv read");
    acc(32'h2020_1010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5, "R5 priv ro priv read");
    acc(32'h2020_1010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5, "R5 priv ro priv write");
    acc(32'h2020_10FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5, "R2 256B top byte");
    acc(32'h2020_1100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 0, "R2 past 256B falls to r0");
    acc(32'h0000_9000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3, "R6 fetch xn region");
    acc(32'h0000_9000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3, "R3 r3 over r2 write");
    acc(32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2, "R5 read only write");
    acc(32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2, "R6 fetch as read");
    acc(32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R2 past 64KB unpriv");
    acc(32'h4000_0800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, "R5 priv only unpriv");
    acc(32'h4000_0800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1, "R5 priv only priv write");
    acc(32'h4000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R2 past 4KB priv bg");

    // R9 unprivileged attempt to disable
    cfg(2'd3, 32'h0000_0000, 1'b0, 1'b1, "R9 unpriv ctrl write");
    acc(32'h2020_6800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R9 ctrl unchanged");
    cfg(2'd2, 32'h0000_0000, 1'b0, 1'b1, "R9 unpriv attr write");
    acc(32'h2020_1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5, "R9 r5 unchanged");

    // R7 background off
    cfg(2'd3, 32'h0000_0001, 1'b1, 1'b0, "R10 ctrl en only");
    acc(32'h2020_6800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 priv miss no bg");

    // R10 disable r4 via direct select then attr
    cfg(2'd1, 32'h2020_7814, 1'b1, 1'b0, "R10 select r4");
    cfg(2'd2, 32'h0300_0014, 1'b1, 1'b0, "R10 r4 off");
    acc(32'h2020_7C00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R4 r0 subregion 7 off");
    acc(32'h2020_7C00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 priv miss no bg");

    // R8 disable everything
    cfg(2'd3, 32'h0000_0004, 1'b1, 1'b0, "R10 ctrl disable");
    acc(32'h2020_6800, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 disabled allow");
    acc(32'h0000_9000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R8 disabled fetch xn");

    @(negedge clk);
    cfg_we = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule